// File: doc/BRIEF.md
# I2C Master Bit Sequencer

This block produces the bus-level waveforms that an I2C controller needs one bit at a time: a START, a repeated START, a STOP, the transmission of a single data bit, and the reception of a single data bit. A byte-level controller above it issues one command at a time and waits for the one-cycle completion strobe. The strobe comes with a status code and, for reads, the sampled bit. The block never drives a line high. It only outputs two drive-low enables, which external open-drain pads turn into pulls toward ground. A released line is read back as high through the bus pull-ups.

All bus timing comes from a half-period count in system clock cycles, given on an input. Wherever the protocol lets SCL rise, the sequencer waits until the sampled SCL really reads high, so a target can stretch the clock. That wait is bounded. If the bound expires, a timeout is recorded and the sequence carries on. The sequencer also compares released SDA against the line, so it can tell when another master has taken the bus. It remembers whether a START is outstanding, so a START issued before a STOP turns into a repeated START.

Top module: `i2cm_bit_engine`

## Requirements
- R1: After reset both drive-low enables are 0, busy is 0 and done is 0, and the bus is considered not started.
- R2: Let D be the half-period input, with 0 counting as 1. A START on a bus that has not been started raises the SDA enable with SCL released, holds it for D cycles, then raises the SCL enable, marks the bus started and completes with status 00.
- R3: A START on a bus that has not been started first checks the synchronised SDA. If SDA reads low, it completes at once with status 10 (arbitration lost), leaves both enables at 0 and clears the started mark, so the next START is a plain one.
- R4: A START on a started bus first releases SDA and SCL. It then waits for SCL to read high and waits D cycles. If SDA reads low at that point it completes with status 10 and both enables 0; otherwise it continues as in R2.
- R5: A STOP pulls SDA low for D cycles, releases SCL, waits for SCL high and waits D cycles. It then releases SDA, clears the started mark and waits 2·D cycles. If SDA then reads low, the status is 10; both enables end at 0.
- R6: A bit write sets the SDA enable to the inverse of the bit for D cycles, releases SCL for D cycles and then waits for SCL high. If the bit is 1 but SDA reads low, it completes with status 10, both enables at 0 and the bus not started. Otherwise it pulls SCL low again and completes.
- R7: A bit read releases SDA for D cycles, releases SCL and waits for SCL high. It then waits D cycles, samples SDA into rd_bit and pulls SCL low as it completes.
- R8: SCL and SDA are sampled through SYNC_STAGES flip-flops. Every wait for SCL high lasts at most STRETCH_LIMIT cycles. On expiry the status becomes 01 (timeout), the sequence continues, and an arbitration loss in the same command overrides it with 10.
- R9: A command is taken only while busy is 0, and commands presented while busy have no effect. done is high for exactly one cycle per command with busy low. While idle the enables do not move, and status and rd_bit hold until the next done.
- R10: A half-period input of 0 gives one-cycle phases.
- R11: The command codes are 00 START, 01 STOP, 10 write bit, 11 read bit. The status codes are 00 ok, 01 timeout and 10 arbitration lost; 11 is never reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_period | input | HP_W | Phase length in clock cycles, 0 treated as 1 |
| cmd_valid | input | 1 | Command request, taken only when idle |
| cmd_op | input | 2 | Command code (R11) |
| cmd_bit | input | 1 | Bit value for a write command |
| scl_in | input | 1 | SCL line level as seen at the pad |
| sda_in | input | 1 | SDA line level as seen at the pad |
| scl_drive_low | output | 1 | Enable pulling SCL to ground |
| sda_drive_low | output | 1 | Enable pulling SDA to ground |
| busy | output | 1 | A command sequence is in progress |
| done | output | 1 | One-cycle completion strobe |
| rd_bit | output | 1 | Last bit sampled by a read |
| status | output | 2 | Completion status (R11) |

## Verification
The assertions assume that cmd_op only ever carries the four defined codes and that half_period does not change while a command runs. The stimulus changes it only between commands. They also assume that the line inputs come from a wired-AND of the block's own enables and a target's pulls, so SCL is never high while the block pulls it low. The bench models that bus with a target that stretches for a chosen number of cycles or forever, and that pulls SDA at chosen moments. It drives the inputs only on falling clock edges, and the duplicate commands it sends while the block is busy use the same legal codes.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

   typedef enum logic [1:0] {
      OP_START = 2'b00,
      OP_STOP  = 2'b01,
      OP_WRITE = 2'b10,
      OP_READ  = 2'b11
   } i2cm_op_e;

   typedef enum logic [1:0] {
      ST_OK      = 2'b00,
      ST_TIMEOUT = 2'b01,
      ST_ARBLOST = 2'b10
   } i2cm_status_e;

   typedef enum logic [3:0] {
      S_IDLE,
      S_RS_WAIT,
      S_RS_SETUP,
      S_ST_HOLD,
      S_SP_LOW,
      S_SP_WAIT,
      S_SP_SETUP,
      S_SP_BUF1,
      S_SP_BUF2,
      S_WR_SETUP,
      S_WR_HIGH,
      S_WR_WAIT,
      S_RD_SETUP,
      S_RD_WAIT,
      S_RD_HIGH
   } i2cm_state_e;

   function automatic logic is_delay_state(i2cm_state_e s);
      case (s)
         S_RS_SETUP, S_ST_HOLD, S_SP_LOW, S_SP_SETUP, S_SP_BUF1,
         S_SP_BUF2, S_WR_SETUP, S_WR_HIGH, S_RD_SETUP, S_RD_HIGH:
            return 1'b1;
         default:
            return 1'b0;
      endcase
   endfunction

   function automatic logic is_wait_state(i2cm_state_e s);
      case (s)
         S_RS_WAIT, S_SP_WAIT, S_WR_WAIT, S_RD_WAIT: return 1'b1;
         default:                                    return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh <= {STAGES{RST_VAL}};
            end else begin
               sh[0] <= d;
               for (int i = 1; i < STAGES; i++) begin
                  sh[i] <= sh[i-1];
               end
            end
         end
         assign q = sh[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
   parameter int HP_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [HP_W-1:0] period,
   output logic            expired
);

   logic [HP_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= (period == '0) ? '0 : period - 1'b1;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/i2cm_stretch_wd.sv
module i2cm_stretch_wd #(
   parameter int LIMIT = 40000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   output logic limit_hit
);

   localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (run) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign limit_hit = (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/i2cm_bit_engine.sv
module i2cm_bit_engine
   import i2cm_pkg::*;
#(
   parameter int HP_W          = 16,
   parameter int STRETCH_LIMIT = 40000,
   parameter int SYNC_STAGES   = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [HP_W-1:0] half_period,
   input  logic            cmd_valid,
   input  logic [1:0]      cmd_op,
   input  logic            cmd_bit,
   input  logic            scl_in,
   input  logic            sda_in,
   output logic            scl_drive_low,
   output logic            sda_drive_low,
   output logic            busy,
   output logic            done,
   output logic            rd_bit,
   output logic [1:0]      status
);

   initial begin
      assert (STRETCH_LIMIT >= 2) else $error("STRETCH_LIMIT must be at least 2");
      assert (HP_W >= 1) else $error("HP_W must be at least 1");
      assert (SYNC_STAGES >= 0) else $error("SYNC_STAGES must not be negative");
   end

   logic scl_s, sda_s;

   i2cm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s)
   );

   i2cm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s)
   );

   i2cm_state_e state_q, state_d;
   logic        scl_q, scl_d;
   logic        sda_q, sda_d;
   logic        started_q, started_d;
   logic        to_q, to_d;
   logic        bit_q, bit_d;
   logic        rd_q, rd_d;
   logic        done_q;
   logic [1:0]  status_q;
   logic        fin, arb;
   logic [1:0]  fin_st;

   logic tick_load, tick_exp;
   logic str_clr, str_run, str_hit;
   logic wait_ok, wait_to, wait_exit;

   i2cm_tick #(.HP_W(HP_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .load(tick_load),
      .period(half_period), .expired(tick_exp)
   );

   i2cm_stretch_wd #(.LIMIT(STRETCH_LIMIT)) u_wd (
      .clk(clk), .rst_n(rst_n), .clr(str_clr), .run(str_run),
      .limit_hit(str_hit)
   );

   assign wait_ok   = scl_s;
   assign wait_to   = !scl_s && str_hit;
   assign wait_exit = wait_ok || wait_to;

   always_comb begin
      state_d   = state_q;
      scl_d     = scl_q;
      sda_d     = sda_q;
      started_d = started_q;
      to_d      = to_q;
      bit_d     = bit_q;
      rd_d      = rd_q;
      fin       = 1'b0;
      arb       = 1'b0;
      str_run   = 1'b0;

      if (is_wait_state(state_q)) begin
         str_run = !wait_exit;
         if (wait_to) to_d = 1'b1;
      end

      case (state_q)
         S_IDLE: begin
            if (cmd_valid) begin
               to_d = 1'b0;
               case (i2cm_op_e'(cmd_op))
                  OP_START: begin
                     if (started_q) begin
                        scl_d   = 1'b0;
                        sda_d   = 1'b0;
                        state_d = S_RS_WAIT;
                     end else if (!sda_s) begin
                        arb = 1'b1;
                     end else begin
                        sda_d   = 1'b1;
                        state_d = S_ST_HOLD;
                     end
                  end
                  OP_STOP: begin
                     sda_d   = 1'b1;
                     state_d = S_SP_LOW;
                  end
                  OP_WRITE: begin
                     bit_d   = cmd_bit;
                     sda_d   = !cmd_bit;
                     state_d = S_WR_SETUP;
                  end
                  default: begin
                     sda_d   = 1'b0;
                     state_d = S_RD_SETUP;
                  end
               endcase
            end
         end
         S_RS_WAIT: if (wait_exit) state_d = S_RS_SETUP;
         S_RS_SETUP: begin
            if (tick_exp) begin
               if (!sda_s) begin
                  arb = 1'b1;
               end else begin
                  sda_d   = 1'b1;
                  state_d = S_ST_HOLD;
               end
            end
         end
         S_ST_HOLD: begin
            if (tick_exp) begin
               scl_d     = 1'b1;
               started_d = 1'b1;
               fin       = 1'b1;
            end
         end
         S_SP_LOW: begin
            if (tick_exp) begin
               scl_d   = 1'b0;
               state_d = S_SP_WAIT;
            end
         end
         S_SP_WAIT: if (wait_exit) state_d = S_SP_SETUP;
         S_SP_SETUP: begin
            if (tick_exp) begin
               sda_d     = 1'b0;
               started_d = 1'b0;
               state_d   = S_SP_BUF1;
            end
         end
         S_SP_BUF1: if (tick_exp) state_d = S_SP_BUF2;
         S_SP_BUF2: begin
            if (tick_exp) begin
               if (!sda_s) arb = 1'b1;
               else        fin = 1'b1;
            end
         end
         S_WR_SETUP: begin
            if (tick_exp) begin
               scl_d   = 1'b0;
               state_d = S_WR_HIGH;
            end
         end
         S_WR_HIGH: if (tick_exp) state_d = S_WR_WAIT;
         S_WR_WAIT: begin
            if (wait_exit) begin
               if (bit_q && !sda_s) begin
                  arb = 1'b1;
               end else begin
                  scl_d = 1'b1;
                  fin   = 1'b1;
               end
            end
         end
         S_RD_SETUP: begin
            if (tick_exp) begin
               scl_d   = 1'b0;
               state_d = S_RD_WAIT;
            end
         end
         S_RD_WAIT: if (wait_exit) state_d = S_RD_HIGH;
         S_RD_HIGH: begin
            if (tick_exp) begin
               rd_d  = sda_s;
               scl_d = 1'b1;
               fin   = 1'b1;
            end
         end
         default: state_d = S_IDLE;
      endcase

      if (arb) begin
         scl_d     = 1'b0;
         sda_d     = 1'b0;
         started_d = 1'b0;
         fin       = 1'b1;
      end
      if (fin) state_d = S_IDLE;

      if (arb)       fin_st = ST_ARBLOST;
      else if (to_d) fin_st = ST_TIMEOUT;
      else           fin_st = ST_OK;
   end

   assign tick_load = (state_d != state_q) && is_delay_state(state_d);
   assign str_clr   = (state_d != state_q) && is_wait_state(state_d);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= S_IDLE;
         scl_q     <= 1'b0;
         sda_q     <= 1'b0;
         started_q <= 1'b0;
         to_q      <= 1'b0;
         bit_q     <= 1'b0;
         rd_q      <= 1'b0;
         done_q    <= 1'b0;
         status_q  <= ST_OK;
      end else begin
         state_q   <= state_d;
         scl_q     <= scl_d;
         sda_q     <= sda_d;
         started_q <= started_d;
         to_q      <= to_d;
         bit_q     <= bit_d;
         rd_q      <= rd_d;
         done_q    <= fin;
         if (fin) status_q <= fin_st;
      end
   end

   assign scl_drive_low = scl_q;
   assign sda_drive_low = sda_q;
   assign busy          = (state_q != S_IDLE);
   assign done          = done_q;
   assign rd_bit        = rd_q;
   assign status        = status_q;

endmodule

// File: rtl/i2cm_bit_engine_chk.sv
module i2cm_bit_engine_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_drive_low,
   input logic       sda_drive_low,
   input logic       busy,
   input logic       done,
   input logic       rd_bit,
   input logic [1:0] status
);

   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R9
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R11
   status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (status != 2'b11));

   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !done) |-> ($stable(scl_drive_low) && $stable(sda_drive_low)));

   // R7
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(rd_bit));

   // R9
   status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(status));

endmodule

bind i2cm_bit_engine i2cm_bit_engine_chk u_chk (
   .clk(clk),
   .rst_n(rst_n),
   .scl_drive_low(scl_drive_low),
   .sda_drive_low(sda_drive_low),
   .busy(busy),
   .done(done),
   .rd_bit(rd_bit),
   .status(status)
);

// File: tb/i2cm_bit_engine_tb.sv
module i2cm_bit_engine_tb;

   localparam int HPW = 8;
   localparam int LIM = 40;
   localparam int SYN = 2;

   localparam logic [1:0] C_START = 2'b00, C_STOP = 2'b01, C_WRITE = 2'b10, C_READ = 2'b11;
   localparam logic [1:0] K_OK = 2'b00, K_TO = 2'b01, K_ARB = 2'b10;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic           rst_n;
   logic [HPW-1:0] hp;
   logic           cmd_valid;
   logic [1:0]     cmd_op;
   logic           cmd_bit;
   logic           tgt_scl_lo, tgt_sda_lo;
   logic           scl_drive_low, sda_drive_low, busy, done, rd_bit;
   logic [1:0]     status;

   wire scl_line = !(scl_drive_low || tgt_scl_lo);
   wire sda_line = !(sda_drive_low || tgt_sda_lo);

   i2cm_bit_engine #(.HP_W(HPW), .STRETCH_LIMIT(LIM), .SYNC_STAGES(SYN)) u_dut (
      .clk(clk), .rst_n(rst_n), .half_period(hp),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bit(cmd_bit),
      .scl_in(scl_line), .sda_in(sda_line),
      .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
      .busy(busy), .done(done), .rd_bit(rd_bit), .status(status)
   );

   // line levels as the design observes them after its input flops
   logic [SYN-1:0] h_scl, h_sda;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_scl <= '1;
         h_sda <= '1;
      end else begin
         h_scl <= {h_scl[SYN-2:0], scl_line};
         h_sda <= {h_sda[SYN-2:0], sda_line};
      end
   end
   wire seen_scl = h_scl[SYN-1];
   wire seen_sda = h_sda[SYN-1];

   int  checks = 0;
   int  errors = 0;
   bit  m_scl, m_sda, m_started, noise, finished;
   int  dly;

   task automatic chk(bit ok, string r, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", r, act, exp, $time);
      end
   endtask

   task automatic set_hp(int v);
      hp  = HPW'(v);
      dly = (v == 0) ? 1 : v;
   endtask

   task automatic idle_cyc(int n);
      for (int i = 0; i < n; i++) begin
         chk(busy == 1'b0, "R9 idle busy", busy, 0);
         chk(done == 1'b0, "R9 idle done", done, 0);
         chk(scl_drive_low == m_scl, "R9 idle scl", scl_drive_low, m_scl);
         chk(sda_drive_low == m_sda, "R9 idle sda", sda_drive_low, m_sda);
         @(negedge clk);
      end
   endtask

   task automatic cyc(string r);
      chk(scl_drive_low == m_scl, r, scl_drive_low, m_scl);
      chk(sda_drive_low == m_sda, r, sda_drive_low, m_sda);
      chk(done == 1'b0, r, done, 0);
      chk(busy == 1'b1, r, busy, 1);
      cmd_valid = noise;
      cmd_op    = C_READ;
      cmd_bit   = 1'b0;
      @(negedge clk);
   endtask

   task automatic hold(int n, string r, output bit s);
      s = 1'b1;
      for (int i = 0; i < n; i++) begin
         s = seen_sda;
         cyc(r);
      end
   endtask

   task automatic wait_hi(int rel, string r, output bit to, output bit s);
      bit hi;
      to = 1'b0;
      for (int k = 0; ; k++) begin
         if (k == rel) tgt_scl_lo = 1'b0;
         s  = seen_sda;
         hi = seen_scl;
         cyc(r);
         if (hi) break;
         if (k == LIM - 1) begin
            to = 1'b1;
            break;
         end
      end
   endtask

   task automatic finish(logic [1:0] st, string r);
      cmd_valid = 1'b0;
      chk(done == 1'b1, r, done, 1);
      chk(busy == 1'b0, r, busy, 0);
      chk(status == st, r, status, st);
      chk(scl_drive_low == m_scl, r, scl_drive_low, m_scl);
      chk(sda_drive_low == m_sda, r, sda_drive_low, m_sda);
      @(negedge clk);
   endtask

   task automatic accept(logic [1:0] op, bit b, int rel, output bit s0);
      tgt_scl_lo = (rel != 0);
      chk(busy == 1'b0, "R9 accept idle", busy, 0);
      chk(done == 1'b0, "R9 done one cycle", done, 0);
      s0        = seen_sda;
      cmd_valid = 1'b1;
      cmd_op    = op;
      cmd_bit   = b;
      @(negedge clk);
   endtask

   task automatic do_start(int rel);
      bit s0, s, to;
      accept(C_START, 1'b0, rel, s0);
      if (m_started) begin
         m_scl = 1'b0;
         m_sda = 1'b0;
         wait_hi(rel, "R4 release", to, s);
         hold(dly, "R4 setup", s);
         if (!s) begin
            m_started = 1'b0;
            finish(K_ARB, "R4 arb");
            return;
         end
         m_sda = 1'b1;
         hold(dly, "R4 hold", s);
         m_scl     = 1'b1;
         m_started = 1'b1;
         finish(to ? K_TO : K_OK, "R4 done");
      end else if (!s0) begin
         m_scl     = 1'b0;
         m_sda     = 1'b0;
         m_started = 1'b0;
         finish(K_ARB, "R3 arb");
      end else begin
         m_sda = 1'b1;
         hold(dly, "R2 hold", s);
         m_scl     = 1'b1;
         m_started = 1'b1;
         finish(K_OK, "R2 done");
      end
   endtask

   task automatic do_stop(int rel);
      bit s0, s, to;
      accept(C_STOP, 1'b0, rel, s0);
      m_sda = 1'b1;
      hold(dly, "R5 low", s);
      m_scl = 1'b0;
      wait_hi(rel, "R5 wait", to, s);
      hold(dly, "R5 setup", s);
      m_sda     = 1'b0;
      m_started = 1'b0;
      hold(dly, "R5 buf1", s);
      hold(dly, "R5 buf2", s);
      finish(!s ? K_ARB : (to ? K_TO : K_OK), "R5 done");
   endtask

   task automatic do_write(bit b, int rel);
      bit s0, s, to;
      accept(C_WRITE, b, rel, s0);
      m_sda = !b;
      hold(dly, "R6 setup", s);
      m_scl = 1'b0;
      hold(dly, "R6 high", s);
      wait_hi(rel, "R8 write wait", to, s);
      if (b && !s) begin
         m_scl     = 1'b0;
         m_sda     = 1'b0;
         m_started = 1'b0;
         finish(K_ARB, "R6 arb");
      end else begin
         m_scl = 1'b1;
         finish(to ? K_TO : K_OK, "R6 done");
      end
   endtask

   task automatic do_read(int rel, bit exp_bit);
      bit s0, s, to;
      tgt_sda_lo = !exp_bit;
      accept(C_READ, 1'b0, rel, s0);
      m_sda = 1'b0;
      hold(dly, "R7 setup", s);
      m_scl = 1'b0;
      wait_hi(rel, "R8 read wait", to, s);
      hold(dly, "R7 high", s);
      m_scl = 1'b1;
      finish(to ? K_TO : K_OK, "R7 done");
      chk(rd_bit == exp_bit, "R7 rd_bit", rd_bit, exp_bit);
      tgt_sda_lo = 1'b0;
   endtask

   initial begin
      finished = 1'b0;
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = C_START; cmd_bit = 1'b0;
      tgt_scl_lo = 1'b0; tgt_sda_lo = 1'b0; noise = 1'b0;
      m_scl = 1'b0; m_sda = 1'b0; m_started = 1'b0;
      set_hp(3);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(scl_drive_low == 1'b0, "R1 scl", scl_drive_low, 0);
      chk(sda_drive_low == 1'b0, "R1 sda", sda_drive_low, 0);
      chk(busy == 1'b0, "R1 busy", busy, 0);
      chk(done == 1'b0, "R1 done", done, 0);
      idle_cyc(3);

      // R2 R6 R7 R4 R5 basic traffic
      do_start(0);
      do_write(1'b1, 0);
      do_write(1'b0, 0);
      do_write(1'b1, 0);
      do_read(0, 1'b0);
      do_read(0, 1'b1);
      do_start(0);
      do_write(1'b0, 0);
      do_stop(0);
      idle_cyc(4);

      // R10 zero half-period
      set_hp(0);
      do_start(0);
      do_write(1'b1, 0);
      do_read(0, 1'b1);
      do_start(0);
      do_stop(0);
      idle_cyc(3);

      // R8 clock stretching
      set_hp(2);
      do_start(0);
      do_write(1'b0, 6);
      do_read(9, 1'b1);
      do_start(4);
      do_stop(5);
      idle_cyc(3);

      // R8 timeout continues and reports 01
      do_start(0);
      do_write(1'b0, -1);
      tgt_scl_lo = 1'b0;
      do_read(-1, 1'b0);
      tgt_scl_lo = 1'b0;
      do_start(-1);
      tgt_scl_lo = 1'b0;
      do_stop(0);
      idle_cyc(3);

      // R3 start with SDA held low, then a plain start
      tgt_sda_lo = 1'b1;
      idle_cyc(3);
      do_start(0);
      tgt_sda_lo = 1'b0;
      idle_cyc(3);
      do_start(0);

      // R6 arbitration on a released 1
      tgt_sda_lo = 1'b1;
      do_write(1'b1, 0);
      tgt_sda_lo = 1'b0;
      idle_cyc(3);

      // R8 arbitration outranks timeout
      do_start(0);
      tgt_sda_lo = 1'b1;
      do_write(1'b1, -1);
      tgt_scl_lo = 1'b0;
      tgt_sda_lo = 1'b0;
      idle_cyc(3);

      // R5 arbitration after stop
      do_start(0);
      tgt_sda_lo = 1'b1;
      do_stop(0);
      tgt_sda_lo = 1'b0;
      idle_cyc(3);

      // R9 commands while busy are ignored
      set_hp(3);
      noise = 1'b1;
      do_start(0);
      do_write(1'b1, 0);
      do_read(0, 1'b0);
      do_stop(0);
      noise = 1'b0;
      idle_cyc(6);
      chk(rd_bit == 1'b0, "R9 rd_bit held", rd_bit, 0);
      chk(status == K_OK, "R9 status held", status, K_OK);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule